// File: doc/BRIEF.md
# DMA Channel Request Front End

This block sits in front of one DMA channel and decides whether a transfer request reaches the bus engine. Software programs three registers through a small write/read port: a cause register that picks one hardware strobe line and can also start a transfer from software, a mode register that enables single-word transfers, and a 16-bit transfer count. A rising edge on the selected strobe, or a software trigger, sets a pending request bit. The block then either raises a one-word transfer request toward the bus engine and holds it until the engine acknowledges, or discards the pending bit when the channel cannot run.

The count drops by one on each acknowledged transfer. When it reaches zero the channel disables itself. Every write to the cause register starts a settling window. Until that window has run out, a pending request is held and no transfer is issued.

Top module: `dma_req_front`

## Requirements
- R1: After reset, all three registers read zero, the channel is disabled, the settling window is idle and `xfer_req` is low.
- R2: A rising edge on `hw_req[code]` sets the pending bit on the next clock. That bit reads as bit 7 of address 0. With a live channel and no settling window open, `xfer_req` rises one clock after that. Edges on lines other than the selected one are ignored.
- R3: A pending bit on a channel that is not live is cleared one clock after it appears, and no transfer is issued. A channel is live when the mode field is 01 and the count is non-zero.
- R4: A write to address 0 with both bit 7 and bit 5 set is a software trigger and sets the pending bit. A write with only one of those two bits set does not set the pending bit. In all three cases, bits [4:0] of the write load the cause code.
- R5: Every write to address 0 reloads a 26-cycle settling counter. A transfer can be issued only after the counter has reached zero. For a write applied at clock edge W, `xfer_req` rises no earlier than edge W+27.
- R6: `xfer_req` stays high until an `xfer_ack` is sampled. Only one request is ever outstanding.
- R7: An acknowledged transfer clears the pending bit and decrements the count. When the count goes from 1 to 0, the mode field returns to 00.
- R8: Writing 0 to bit 7 of address 0 leaves the pending bit unchanged.
- R9: The register map is as follows. Address 0 holds the cause code in [4:0] and the pending bit in [7]; bits 6:5 read 0. Address 1 holds the mode in [1:0], where 00 means disabled and 01 means single transfer. Address 2 holds the count. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Register address |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data for `cpu_addr`, combinational |
| hw_req | input | NSRC | Hardware request strobes, one per cause code |
| xfer_req | output | 1 | Single-word transfer request to the bus engine |
| xfer_ack | input | 1 | Transfer acknowledge from the bus engine |

## Verification
Each result lands at a fixed clock after its stimulus:
- A register write is visible on the read port in the cycle after the write edge.
- A hardware edge shows as the pending bit one cycle after the edge, and as `xfer_req` two cycles after it.
- A discard clears the pending bit two cycles after the edge.
- A cause write delays `xfer_req` until the 28th cycle after the cycle that drove the write.
- An acknowledge drops `xfer_req` and updates the count one cycle later.

The driver converts each of these latencies into an absolute cycle number when it pushes the expectation. The monitor compares each expectation only in that exact cycle, at the falling clock edge. Settling checks also expect `xfer_req` to be low in the cycle just before it is due.

// File: rtl/dma_req_front.sv
module dma_req_front #(
  parameter int NSRC   = 32,
  parameter int CNT_W  = 16,
  parameter int SETTLE = 26,
  localparam int SEL_W = $clog2(NSRC),
  localparam int ST_W  = $clog2(SETTLE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_we,
  input  logic [1:0]       cpu_addr,
  input  logic [CNT_W-1:0] cpu_wdata,
  output logic [CNT_W-1:0] cpu_rdata,
  input  logic [NSRC-1:0]  hw_req,
  output logic             xfer_req,
  input  logic             xfer_ack
);

  logic [SEL_W-1:0] code;
  logic             pend;
  logic             busy;
  logic [1:0]       mode;
  logic [CNT_W-1:0] count;
  logic [ST_W-1:0]  settle;
  logic [NSRC-1:0]  hw_q;

  wire wr_sel  = cpu_we && cpu_addr == 2'd0;
  wire wr_mode = cpu_we && cpu_addr == 2'd1;
  wire wr_cnt  = cpu_we && cpu_addr == 2'd2;

  wire enabled = mode == 2'b01;
  wire live    = enabled && count != '0;
  wire hw_rise = hw_req[code] && !hw_q[code];
  wire sw_trig = wr_sel && cpu_wdata[7] && cpu_wdata[5];
  wire done    = busy && xfer_ack;
  wire issue   = pend && !busy && live && settle == '0;
  wire drop    = pend && !busy && !live;

  assign xfer_req = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code   <= '0;
      pend   <= 1'b0;
      busy   <= 1'b0;
      mode   <= 2'b00;
      count  <= '0;
      settle <= '0;
      hw_q   <= '0;
    end else begin
      hw_q <= hw_req;
      if (wr_sel) code <= cpu_wdata[SEL_W-1:0];

      if (hw_rise || sw_trig)  pend <= 1'b1;
      else if (done || drop)   pend <= 1'b0;

      if (done)       busy <= 1'b0;
      else if (issue) busy <= 1'b1;

      if (wr_cnt)    count <= cpu_wdata;
      else if (done) count <= count - 1'b1;

      if (wr_mode)                          mode <= cpu_wdata[1:0];
      else if (done && count == CNT_W'(1))  mode <= 2'b00;

      if (wr_sel)              settle <= ST_W'(SETTLE);
      else if (settle != '0)   settle <= settle - 1'b1;
    end
  end

  always_comb begin
    case (cpu_addr)
      2'd0:    cpu_rdata = CNT_W'(code) | (CNT_W'(pend) << 7);
      2'd1:    cpu_rdata = CNT_W'(mode);
      2'd2:    cpu_rdata = count;
      default: cpu_rdata = '0;
    endcase
  end

  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_ack |=> xfer_req);

  assert_busy_has_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> pend);

  assert_settled_before_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_req) |-> $past(settle) == '0);

  assert_live_before_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_req) |-> $past(live));

  assert_count_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && xfer_ack && !wr_cnt |=> count == CNT_W'($past(count) - 1'b1));

  assert_mode_off_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && xfer_ack && !wr_mode && count == CNT_W'(1) |=> mode == 2'b00);

endmodule

// File: tb/dma_req_front_tb.sv
module dma_req_front_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_we = 1'b0;
  logic [1:0]  cpu_addr = 2'd0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic [NSRC-1:0] hw_req = '0;
  logic        xfer_req;
  logic        xfer_ack = 1'b0;

  dma_req_front #(.NSRC(NSRC), .CNT_W(16), .SETTLE(26)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .hw_req(hw_req),
    .xfer_req(xfer_req), .xfer_ack(xfer_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int          cyc;
    bit          is_read;
    logic [15:0] val;
    string       tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int n_checks = 0;
  int n_fails = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc == cyc) begin
        logic [15:0] got;
        got = q[i].is_read ? cpu_rdata : {15'd0, xfer_req};
        n_checks++;
        if (got !== q[i].val) begin
          n_fails++;
          $display("FAIL %s cycle %0d %s: got %h expected %h", q[i].tag, cyc,
                   q[i].is_read ? "read" : "xfer_req", got, q[i].val);
        end
        q.delete(i);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    tick();
    cpu_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [15:0] exp_v, string tag);
    cpu_addr = a;
    q.push_back('{cyc, 1'b1, exp_v, tag});
    tick();
  endtask

  task automatic exp_x(int c, bit v, string tag);
    q.push_back('{c, 1'b0, {15'd0, v}, tag});
  endtask

  task automatic summary();
    foreach (q[i]) begin
      n_checks++; n_fails++;
      $display("FAIL %s: check at cycle %0d never made, got none expected %h",
               q[i].tag, q[i].cyc, q[i].val);
    end
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int t;
    tick(3);
    rst_n = 1'b1;
    // R1: reset state
    exp_x(cyc, 0, "R1");
    rd(2'd0, 16'h0000, "R1");
    rd(2'd1, 16'h0000, "R1");
    rd(2'd2, 16'h0000, "R1");
    rd(2'd3, 16'h0000, "R9");

    // Setup: select line 3 with bit 7 alone (R4: must not set pending)
    wr(2'd0, 16'h0083);
    rd(2'd0, 16'h0003, "R4");
    wr(2'd2, 16'd3);
    rd(2'd2, 16'd3, "R9");
    tick(30);
    wr(2'd1, 16'h0001);
    rd(2'd1, 16'h0001, "R9");

    // R2: edge on an unselected line is ignored
    hw_req[5] = 1'b1; t = cyc;
    for (int k = 1; k <= 3; k++) exp_x(t + k, 0, "R2");
    tick();
    rd(2'd0, 16'h0003, "R2");
    tick(2);
    hw_req[5] = 1'b0;

    // R2/R6/R8/R7: selected line edge, held request, write-0 ignored, ack
    hw_req[3] = 1'b1; t = cyc;
    exp_x(t + 1, 0, "R2");
    for (int k = 2; k <= 6; k++) exp_x(t + k, 1, "R6");
    exp_x(t + 7, 0, "R7");
    tick();
    rd(2'd0, 16'h0083, "R2");
    tick();
    wr(2'd0, 16'h0003);
    rd(2'd0, 16'h0083, "R8");
    tick();
    xfer_ack = 1'b1;
    tick();
    xfer_ack = 1'b0;
    hw_req[3] = 1'b0;
    rd(2'd2, 16'd2, "R7");
    rd(2'd0, 16'h0003, "R7");

    // R5: settling window and its restart
    tick(30);
    t = cyc;
    wr(2'd0, 16'h0003);
    hw_req[3] = 1'b1;
    exp_x(t + 28, 0, "R5");
    exp_x(t + 37, 0, "R5");
    exp_x(t + 38, 1, "R5");
    exp_x(t + 40, 0, "R7");
    tick(3);
    rd(2'd0, 16'h0083, "R5");
    while (cyc < t + 10) tick();
    wr(2'd0, 16'h0003);
    while (cyc < t + 39) tick();
    xfer_ack = 1'b1;
    tick();
    xfer_ack = 1'b0;
    hw_req[3] = 1'b0;
    rd(2'd2, 16'd1, "R7");

    // R4: bit 5 alone does not trigger
    tick(30);
    t = cyc;
    wr(2'd0, 16'h0023);
    for (int k = 1; k <= 30; k++) exp_x(t + k, 0, "R4");
    rd(2'd0, 16'h0003, "R4");
    tick(30);

    // R4: bits 7 and 5 together trigger after settling
    t = cyc;
    wr(2'd0, 16'h00A3);
    exp_x(t + 27, 0, "R5");
    exp_x(t + 28, 1, "R4");
    exp_x(t + 29, 0, "R7");
    rd(2'd0, 16'h0083, "R4");
    while (cyc < t + 28) tick();
    xfer_ack = 1'b1;
    tick();
    xfer_ack = 1'b0;
    rd(2'd1, 16'h0000, "R7");
    rd(2'd2, 16'h0000, "R7");

    // R3: request on disabled channel is discarded
    tick(3);
    hw_req[3] = 1'b1; t = cyc;
    for (int k = 1; k <= 5; k++) exp_x(t + k, 0, "R3");
    tick();
    rd(2'd0, 16'h0083, "R3");
    rd(2'd0, 16'h0003, "R3");
    tick(3);
    hw_req[3] = 1'b0;

    // R3: enabled but count zero is discarded
    wr(2'd1, 16'h0001);
    tick();
    hw_req[3] = 1'b1; t = cyc;
    for (int k = 1; k <= 5; k++) exp_x(t + k, 0, "R3");
    tick(2);
    rd(2'd0, 16'h0003, "R3");
    rd(2'd2, 16'h0000, "R3");
    tick(4);
    hw_req[3] = 1'b0;
    tick(2);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule